// File: doc/BRIEF.md
# Serial-Load Latched Output Driver

This block loads a bit stream through a serial input into a chain of storage stages. Each stage feeds its own latch, and the latch contents drive a bank of parallel outputs. A bit enters the first stage on a clock edge at which the shift strobe is high. Every bit already in the chain moves one stage further at the same edge. The last stage appears on a serial output, so several copies can be chained to widen the output bank.

The latch control decides whether the latches follow the chain or hold their contents. While it is high, the latches pass the chain through, so a freshly shifted bit reaches output 1 on the same edge. While it is low, the latches keep their values whatever the chain does.

The parallel pins are active low: a stored 1 turns its driver on, and the pin then reads 0. A force-off input turns every driver off without disturbing the latch contents. Everything is synchronous to one clock and has a synchronous active-high reset. Reset clears the chain and the latches, which leaves every driver off.

Top module: `serial_latch_driver`

## Requirements
- R1: When `rst` is high at a clock edge, after that edge every `pout` bit is 1 and `ser_out` is 0.
- R2: At an edge with `shift_en` high, stage 1 takes `ser_in` and stage k+1 takes the old content of stage k. At an edge with `shift_en` low the chain holds.
- R3: `ser_out` is the content of the last stage. It therefore equals the bit shifted in STAGES shift edges earlier, and it changes only at edges with `shift_en` high, never through `latch_en`.
- R4: At an edge with `latch_en` high, the latches take the chain value that results from that same edge. With `shift_en` also high, `pout[0]` shows the new bit, and `pout[i]` shows stage i+1 in order.
- R5: At an edge with `latch_en` low, the latch contents are unchanged, so `pout` is unchanged while `out_off` stays low.
- R6: `pout[i]` is 0 (driver on) when latch i holds 1 and `out_off` is low, and 1 (driver off) otherwise.
- R7: At an edge with `out_off` high, all `pout` bits become 1. The latch contents are kept, and they reappear on `pout` at the first edge with `out_off` low.
- R8: A pulse on `latch_en` with `shift_en` low copies the whole chain into the latches in one edge.
- R9: With two instances chained (`ser_out` of the first feeding `ser_in` of the second), 16 shifted bits followed by one latch pulse leave the most recent bit on output 1 of the first instance. The oldest bit ends on the last output of the second instance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Shift strobe; chain advances at edges where high |
| ser_in | input | 1 | Serial data into stage 1 |
| latch_en | input | 1 | High: latches follow the chain; low: latches hold |
| out_off | input | 1 | High: every driver forced off |
| ser_out | output | 1 | Last stage, for cascading |
| pout | output | STAGES | Active-low parallel drivers, bit 0 = output 1 |

## Verification
A stage that holds a wrong bit shows up as soon as that bit is latched, either through a transparent shift or a latch pulse. It also shows on `ser_out` at the latest STAGES shift edges later. A corrupted latch shows on `pout` at the very next edge with `out_off` low, because the output register is loaded from the next latch value. An output that ignores force-off, or that loses its latch value during force-off, is exposed within one edge of `out_off` changing. The two-instance chain catches any misordering of stages, since misplaced bits land on visibly wrong outputs of either instance.

// File: rtl/serial_latch_driver_pkg.sv
package serial_latch_driver_pkg;
  localparam int unsigned SLD_DEFAULT_STAGES = 8;

  // Active-low pin level from stored bit and force-off
  function automatic logic pin_level(input logic stored, input logic off);
    return ~(stored & ~off);
  endfunction
endpackage

// File: rtl/sld_shift_chain.sv
module sld_shift_chain #(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              ser_in,
  output logic [STAGES-1:0] chain_nxt,
  output logic              ser_out
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign chain_nxt[i] = shift_en ? ser_in : chain_q[i];
    end else begin : g_body
      assign chain_nxt[i] = shift_en ? chain_q[i-1] : chain_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= chain_nxt;
  end

  assign ser_out = chain_q[STAGES-1];
endmodule

// File: rtl/sld_latch_bank.sv
module sld_latch_bank #(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_en,
  input  logic [STAGES-1:0] chain_nxt,
  output logic [STAGES-1:0] hold_nxt
);
  logic [STAGES-1:0] hold_q;

  // Transparent while latch_en high: take the chain value of this edge
  assign hold_nxt = latch_en ? chain_nxt : hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= hold_nxt;
  end
endmodule

// File: rtl/sld_out_stage.sv
module sld_out_stage
  import serial_latch_driver_pkg::*;
#(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              out_off,
  input  logic [STAGES-1:0] hold_nxt,
  output logic [STAGES-1:0] pout
);
  for (genvar i = 0; i < STAGES; i++) begin : g_drv
    logic pin_q;
    always_ff @(posedge clk) begin
      if (rst) pin_q <= 1'b1;
      else     pin_q <= pin_level(hold_nxt[i], out_off);
    end
    assign pout[i] = pin_q;
  end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
  import serial_latch_driver_pkg::*;
#(
  parameter int unsigned STAGES = SLD_DEFAULT_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              ser_in,
  input  logic              latch_en,
  input  logic              out_off,
  output logic              ser_out,
  output logic [STAGES-1:0] pout
);
  logic [STAGES-1:0] chain_nxt;
  logic [STAGES-1:0] hold_nxt;

  sld_shift_chain #(.STAGES(STAGES)) u_chain (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
    .chain_nxt(chain_nxt), .ser_out(ser_out)
  );

  sld_latch_bank #(.STAGES(STAGES)) u_hold (
    .clk(clk), .rst(rst), .latch_en(latch_en),
    .chain_nxt(chain_nxt), .hold_nxt(hold_nxt)
  );

  sld_out_stage #(.STAGES(STAGES)) u_out (
    .clk(clk), .rst(rst), .out_off(out_off),
    .hold_nxt(hold_nxt), .pout(pout)
  );
endmodule

// File: rtl/serial_latch_driver_chk.sv
module serial_latch_driver_chk #(
  parameter int unsigned STAGES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              shift_en,
  input logic              ser_in,
  input logic              latch_en,
  input logic              out_off,
  input logic              ser_out,
  input logic [STAGES-1:0] pout
);
  a_r1_reset_off: assert property (@(posedge clk)
    rst |=> ((&pout) && !ser_out));

  a_r3_serout_only_on_shift: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(ser_out));

  a_r4_new_bit_on_out1: assert property (@(posedge clk) disable iff (rst)
    (shift_en && latch_en && !out_off) |=> (pout[0] == ~$past(ser_in)));

  a_r5_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    (!latch_en && !out_off && $past(!out_off)) |=> $stable(pout));

  a_r7_force_off: assert property (@(posedge clk) disable iff (rst)
    out_off |=> (&pout));
endmodule

bind serial_latch_driver serial_latch_driver_chk #(.STAGES(STAGES)) u_sld_chk (
  .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
  .latch_en(latch_en), .out_off(out_off), .ser_out(ser_out), .pout(pout)
);

// File: tb/test_serial_latch_driver.sv
`timescale 1ns/1ps
module test_serial_latch_driver;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b0, ser_in = 1'b0, latch_en = 1'b0, out_off = 1'b0;
  logic ser_a, ser_b;
  logic [NS-1:0] pout_a, pout_b;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_latch_driver #(.STAGES(NS)) i_serial_latch_driver (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
    .latch_en(latch_en), .out_off(out_off), .ser_out(ser_a), .pout(pout_a)
  );

  serial_latch_driver #(.STAGES(NS)) i_serial_latch_driver_b (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_a),
    .latch_en(latch_en), .out_off(out_off), .ser_out(ser_b), .pout(pout_b)
  );

  typedef struct packed {
    logic       sh;
    logic       d;
    logic       la;
    logic       off;
    logic [7:0] exp_p;
    logic       exp_so;
  } vec_t;

  // Expected pins are active low; chain state noted per row
  localparam vec_t TBL [13] = '{
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'hFE, 1'b0}, // chain 01, transparent      R4 R6
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'hFD, 1'b0}, // chain 02                   R2 R4
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'hFD, 1'b0}, // chain 05, held             R5
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'hFA, 1'b0}, // latch pulse, no shift      R8 R2
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0}, // force off                  R7
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'hFA, 1'b0}, // restored                   R7
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'hF4, 1'b0}, // chain 0B                   R4
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'hE9, 1'b0}, // chain 16
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'hD3, 1'b0}, // chain 2C
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'hA7, 1'b0}, // chain 58
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'h4F, 1'b1}, // chain B0, last stage 1     R3
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'h4F, 1'b1}, // no shift, serial holds     R3
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0}  // chain 60, off              R3 R7
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at next falling edge
  task automatic step(input logic sh, input logic d, input logic la, input logic off);
    shift_en = sh; ser_in = d; latch_en = la; out_off = off;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic [7:0]  ea, eb;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 reset pout", {8'h0, pout_a}, 16'h00FF);
    chk("R1 reset ser_out", {15'h0, ser_a}, 16'h0);

    for (int k = 0; k < 13; k++) begin
      step(TBL[k].sh, TBL[k].d, TBL[k].la, TBL[k].off);
      chk($sformatf("R2/R4/R5/R6/R8 row %0d pout", k), {8'h0, pout_a}, {8'h0, TBL[k].exp_p});
      chk($sformatf("R3 row %0d ser_out", k), {15'h0, ser_a}, {15'h0, TBL[k].exp_so});
    end

    // R1 mid-run reset with latches transparent and drivers enabled
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R1 midrun pout", {8'h0, pout_a}, 16'h00FF);
    chk("R1 midrun ser_out", {15'h0, ser_a}, 16'h0);
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b0, 1'b0);

    // R9 cascade: 16 bits with latches held
    w = 16'hA5C3;
    for (int k = 0; k < 16; k++) step(1'b1, w[k], 1'b0, 1'b0);
    chk("R5 cascade held A", {8'h0, pout_a}, 16'h00FF);
    chk("R5 cascade held B", {8'h0, pout_b}, 16'h00FF);
    chk("R3 cascade ser_out B oldest bit", {15'h0, ser_b}, {15'h0, w[0]});
    step(1'b0, 1'b0, 1'b1, 1'b0);
    for (int j = 0; j < 8; j++) begin
      ea[j] = ~w[15-j];
      eb[j] = ~w[7-j];
    end
    chk("R9 cascade A", {8'h0, pout_a}, {8'h0, ea});
    chk("R9 cascade B", {8'h0, pout_b}, {8'h0, eb});

    // R7 force-off then release keeps latched data
    step(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R7 off A", {8'h0, pout_a}, 16'h00FF);
    chk("R7 off B", {8'h0, pout_b}, 16'h00FF);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 restore A", {8'h0, pout_a}, {8'h0, ea});
    chk("R5 hold after shift B", {8'h0, pout_b}, {8'h0, eb});

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule